// File: doc/BRIEF.md
# Bus-Stealing Block Transfer Controller

This block sits on the peripheral side of a shared system bus and takes the bus away from the processor to run a block transfer. Software sets a start address, a word count, a fill value and a direction, then writes a trigger register. The controller then asks for the bus with an active-low request. It makes that request only while phase two is low and the video controller's bus-available line is high. Because the processor's next cycle after the trigger write is an instruction fetch, the processor is always stalled on a read, never on a write.

Once the request is low, the controller drives one word onto the bus in each phase-two-high interval. The address steps up by one and the remaining count steps down by one for each word. If bus-available drops, the controller stops driving at once but keeps the request low. It waits until bus-available is high again during phase two low, then repeats the word that was interrupted. When the count reaches zero it releases the request, and the processor finishes its stalled read.

The state machine has five states. IDLE accepts register writes. ARM waits for phase two low with bus-available high. XFER drives words. PAUSE holds the request with the bus released. RELEASE is a one-cycle exit.

The transitions are:
- IDLE→ARM on a trigger with a nonzero count.
- IDLE→IDLE on a trigger with a zero count.
- ARM→XFER when phase two is low and bus-available is high.
- XFER→PAUSE when bus-available is low.
- XFER→RELEASE when the last word completes.
- PAUSE→XFER when phase two is low and bus-available is high.
- RELEASE→IDLE unconditionally.

The phase-two and bus-available inputs are synchronous to `clk`.

Top module: `extdma_top`

## Requirements
- R1: While reset is held and directly after it, `dma_n` is 1, `bus_drive` is 0 and `len_left` is 0.
- R2: Register writes (`reg_wr` high at a clock edge) decode `reg_sel` as follows. 0 loads the start address. 1 loads the word count. 2 loads the fill value (low `DATA_W` bits). 3 is the trigger, and its `reg_wdata[0]` gives the direction. Direction 1 means the controller writes memory, so `rw_out`=0. Direction 0 means it reads, so `rw_out`=1. While driving, `data_out` shows the fill value.
- R3: A trigger with a nonzero count arms the controller. `dma_n` falls only at a clock edge where `phi2` is 0 and `bus_avail` is 1. While `bus_avail` stays 0, the request stays high.
- R4: `bus_drive` is 1 only while `phi2` is 1, `bus_avail` is 1 and `dma_n` is 0, so the controller never drives in phase one.
- R5: Exactly one word is moved per phase-two-high interval. The first address is the start address. At the clock edge that sees `phi2` fall after a driven interval, `addr_out` increments (modulo 2^`ADDR_W`) and `len_left` decrements.
- R6: When `bus_avail` goes low, `bus_drive` drops in the same cycle and `dma_n` stays 0. Driving resumes only after an edge with `phi2` low and `bus_avail` high. An interval cut short is not counted.
- R7: At the edge that completes the last word, `dma_n` returns to 1. `len_left` is then 0 and `addr_out` is the start address plus the count.
- R8: A trigger with a zero count never lowers `dma_n` and never drives the bus.
- R9: Register writes, including triggers, are ignored while a transfer is in progress (any state other than IDLE).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phi2 | input | 1 | Phase-two level, synchronous to clk |
| bus_avail | input | 1 | Bus-available from the video controller, high when the bus may be taken |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | REG_W | Register write data |
| dma_n | output | 1 | Active-low bus request to the processor |
| bus_drive | output | 1 | Enable for the address, data and read-write drivers |
| addr_out | output | ADDR_W | Current transfer address |
| data_out | output | DATA_W | Word driven on the data bus (fill value) |
| rw_out | output | 1 | Read-write line, 1 for read |
| len_left | output | LEN_W | Words still to move |

## Verification
The hardest situation to reach is a bus-available gap in the middle of a job. The gap must open after a word has been counted and while phase two is low, and it must close at an arbitrary phase. The bench waits for the remaining count to reach a chosen value and then drops bus-available on the next falling clock edge, which lies inside the same phase-two-low interval. It holds the line low for many cycles, checking that the request stays low and the bus stays released. It then raises the line during phase two high, so the resume must wait for the next low phase. A second hard case is a trigger armed while bus-available is already low. Separate jobs cover writes issued mid-transfer, a zero count and address wrap.

// File: rtl/extdma_pkg.sv
package extdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_XFER,
        ST_PAUSE,
        ST_RELEASE
    } dma_state_e;

    localparam logic [1:0] SEL_BASE = 2'd0;
    localparam logic [1:0] SEL_LEN  = 2'd1;
    localparam logic [1:0] SEL_FILL = 2'd2;
    localparam logic [1:0] SEL_GO   = 2'd3;

endpackage

// File: rtl/extdma_phase.sv
module extdma_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic phi2,
    output logic phi2_fall
);
    logic phi2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) phi2_q <= 1'b0;
        else        phi2_q <= phi2;
    end

    assign phi2_fall = phi2_q & ~phi2;

endmodule

// File: rtl/extdma_cfg.sv
module extdma_cfg #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 8,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [REG_W-1:0]  wdata,
    output logic [ADDR_W-1:0] base,
    output logic [LEN_W-1:0]  len,
    output logic [DATA_W-1:0] fill,
    output logic              dir_wr,
    output logic              go
);
    import extdma_pkg::*;

    assign go = wr_en && (sel == SEL_GO);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base   <= '0;
            len    <= '0;
            fill   <= '0;
            dir_wr <= 1'b0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_BASE: base   <= wdata[ADDR_W-1:0];
                SEL_LEN:  len    <= wdata[LEN_W-1:0];
                SEL_FILL: fill   <= wdata[DATA_W-1:0];
                SEL_GO:   dir_wr <= wdata[0];
                default:  ;
            endcase
        end
    end

    AST_GO_DIR: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && sel == SEL_GO) |=> (dir_wr == $past(wdata[0]))); // R2

endmodule

// File: rtl/extdma_walker.sv
module extdma_walker #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [LEN_W-1:0]  len_in,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  remain,
    output logic              last
);
    localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            remain <= '0;
        end else if (load) begin
            addr   <= base_in;
            remain <= len_in;
        end else if (step) begin
            addr   <= addr + ADDR_ONE;
            remain <= remain - LEN_ONE;
        end
    end

    assign last = (remain == LEN_ONE);

    AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (step && !load) |=> (remain == $past(remain) - LEN_ONE) && (addr == $past(addr) + ADDR_ONE)); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (step && !load) |-> (remain != '0)); // R5
    AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (!step && !load) |=> $stable(remain) && $stable(addr)); // R9

endmodule

// File: rtl/extdma_seq.sv
module extdma_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic len_zero,
    input  logic phi2,
    input  logic phi2_fall,
    input  logic bus_avail,
    input  logic last,
    output logic load,
    output logic step,
    output logic idle,
    output logic dma_n,
    output logic bus_drive
);
    import extdma_pkg::*;

    dma_state_e state, nxt;
    logic       beat;
    logic       slot_ok;

    assign slot_ok = !phi2 && bus_avail;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (go && !len_zero) nxt = ST_ARM;
            ST_ARM:     if (slot_ok) nxt = ST_XFER;
            ST_XFER: begin
                if (!bus_avail)               nxt = ST_PAUSE;
                else if (phi2_fall && beat && last) nxt = ST_RELEASE;
            end
            ST_PAUSE:   if (slot_ok) nxt = ST_XFER;
            ST_RELEASE: nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            beat  <= 1'b0;
        end else begin
            state <= nxt;
            if (step || state != ST_XFER || !bus_avail) beat <= 1'b0;
            else if (bus_drive)                         beat <= 1'b1;
        end
    end

    always_comb begin
        idle      = (state == ST_IDLE);
        load      = idle && go;
        step      = (state == ST_XFER) && bus_avail && phi2_fall && beat;
        dma_n     = !((state == ST_XFER) || (state == ST_PAUSE));
        bus_drive = (state == ST_XFER) && phi2 && bus_avail;
    end

    AST_ARM_SLOT: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_ARM && !(slot_ok)) |=> (state == ST_ARM)); // R3
    AST_PAUSE_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_PAUSE && !bus_avail) |=> (state == ST_PAUSE)); // R6
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_IDLE && go && len_zero) |=> (state == ST_IDLE)); // R8
    AST_STEP_AFTER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) step |-> $past(bus_drive)); // R5
    AST_RELEASE_ONE: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_RELEASE) |=> (state == ST_IDLE)); // R7

endmodule

// File: rtl/extdma_top.sv
module extdma_top #(
    parameter int  ADDR_W = 16,
    parameter int  LEN_W  = 16,
    parameter int  DATA_W = 8,
    localparam int AL_W   = (ADDR_W > LEN_W) ? ADDR_W : LEN_W,
    localparam int REG_W  = (AL_W > DATA_W) ? AL_W : DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic              bus_avail,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic              dma_n,
    output logic              bus_drive,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] data_out,
    output logic              rw_out,
    output logic [LEN_W-1:0]  len_left
);
    logic              phi2_fall;
    logic              idle;
    logic              wr_ok;
    logic              go;
    logic              load;
    logic              step;
    logic              last;
    logic              dir_wr;
    logic [ADDR_W-1:0] cfg_base;
    logic [LEN_W-1:0]  cfg_len;

    assign wr_ok = reg_wr && idle;

    extdma_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .phi2      (phi2),
        .phi2_fall (phi2_fall)
    );

    extdma_cfg #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .DATA_W (DATA_W),
        .REG_W  (REG_W)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ok),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .base   (cfg_base),
        .len    (cfg_len),
        .fill   (data_out),
        .dir_wr (dir_wr),
        .go     (go)
    );

    extdma_walker #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .base_in (cfg_base),
        .len_in  (cfg_len),
        .addr    (addr_out),
        .remain  (len_left),
        .last    (last)
    );

    extdma_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .len_zero  (cfg_len == '0),
        .phi2      (phi2),
        .phi2_fall (phi2_fall),
        .bus_avail (bus_avail),
        .last      (last),
        .load      (load),
        .step      (step),
        .idle      (idle),
        .dma_n     (dma_n),
        .bus_drive (bus_drive)
    );

    assign rw_out = ~dir_wr;

    AST_REQ_SLOT: assert property (@(posedge clk) disable iff (!rst_n) $fell(dma_n) |-> $past(!phi2 && bus_avail)); // R3
    AST_DRIVE_PHASE: assert property (@(posedge clk) disable iff (!rst_n) bus_drive |-> (phi2 && bus_avail && !dma_n)); // R4
    AST_BUSY_WRITES: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr && !dma_n) |=> ($stable(cfg_base) && $stable(cfg_len))); // R9
    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) $rose(dma_n) |-> (len_left == '0)); // R7

endmodule

// File: tb/sim_extdma_top.sv
module sim_extdma_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 16;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
        logic              rw;
        logic [LEN_W-1:0]  rem;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic phi2 = 1'b0;
    logic bus_avail = 1'b1;
    logic reg_wr = 1'b0;
    logic [1:0] reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic dma_n, bus_drive, rw_out;
    logic [ADDR_W-1:0] addr_out;
    logic [DATA_W-1:0] data_out;
    logic [LEN_W-1:0] len_left;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int fail_win = 0;
    exp_t q[$];

    extdma_top #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .bus_avail(bus_avail),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .dma_n(dma_n), .bus_drive(bus_drive), .addr_out(addr_out),
        .data_out(data_out), .rw_out(rw_out), .len_left(len_left)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // phase generator: four clocks low, four high
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            cnt++;
            phi2 = ((cnt % 8) >= 4);
        end
    end

    // monitor: pops the scoreboard at the start of each driven interval
    initial begin
        logic pd = 1'b0, pdma = 1'b1, pphi = 1'b0, pba = 1'b1;
        forever begin
            @(negedge clk); #1;
            if (rst_n) begin
                if (bus_drive && !pd) begin
                    exp_t e;
                    if (q.size() == 0) begin
                        check(1'b0, "R5 unexpected word", 32'(addr_out), 32'hFFFF_FFFF);
                    end else begin
                        e = q.pop_front();
                        check(addr_out == e.a, "R5 address", 32'(addr_out), 32'(e.a));
                        check(len_left == e.rem, "R5 remaining", 32'(len_left), 32'(e.rem));
                        check(data_out == e.d && rw_out == e.rw, "R2 data/rw", {23'd0, rw_out, data_out}, {23'd0, e.rw, e.d});
                    end
                    check(phi2 && bus_avail && !dma_n, "R4 drive window", {29'd0, phi2, bus_avail, dma_n}, 32'b110);
                end
                if (bus_drive && (!phi2 || !bus_avail || dma_n))
                    check(1'b0, "R4 drive outside window", {29'd0, phi2, bus_avail, dma_n}, 32'b110);
                if (pdma && !dma_n)
                    check(!pphi && pba, "R3 request slot", {30'd0, pphi, pba}, 32'b01);
            end
            pd = bus_drive; pdma = dma_n; pphi = phi2; pba = bus_avail;
        end
    end

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                check(1'b0, "watchdog", 32'(cyc), 32'd150000);
                $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
                $finish;
            end
        end
    end

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic push_job(input logic [15:0] base, input logic [15:0] len, input logic [7:0] fill, input bit dir);
        for (int i = 0; i < int'(len); i++) begin
            exp_t e;
            e.a = base + ADDR_W'(i);
            e.d = fill;
            e.rw = ~dir;
            e.rem = len - LEN_W'(i);
            q.push_back(e);
        end
    endtask

    task automatic wait_done;
        do begin @(negedge clk); #2; end while (dma_n);
        do begin @(negedge clk); #2; end while (!dma_n);
    endtask

    task automatic end_checks(input logic [15:0] base, input logic [15:0] len, input string tag);
        check(len_left == 0, {tag, " R7 count empty"}, 32'(len_left), 0);
        check(addr_out == base + len, {tag, " R7 final address"}, 32'(addr_out), 32'(base + len));
        check(q.size() == 0, {tag, " R5 all words seen"}, 32'(q.size()), 0);
    endtask

    task automatic run_job(input logic [15:0] base, input logic [15:0] len, input logic [7:0] fill, input bit dir);
        wr(2'd0, base);
        wr(2'd1, len);
        wr(2'd2, {8'd0, fill});
        push_job(base, len, fill, dir);
        wr(2'd3, {15'd0, dir});
    endtask

    initial begin
        int held;
        repeat (3) @(negedge clk);
        #1;
        check(dma_n == 1'b1 && bus_drive == 1'b0 && len_left == 0, "R1 during reset", {15'd0, dma_n, bus_drive, len_left}, 32'h0002_0000);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        check(dma_n == 1'b1 && bus_drive == 1'b0 && len_left == 0, "R1 after reset", {15'd0, dma_n, bus_drive, len_left}, 32'h0002_0000);

        // read job of three words
        run_job(16'h1000, 16'd3, 8'hA5, 1'b0);
        wait_done();
        end_checks(16'h1000, 16'd3, "job1");

        // write job with a bus-available gap, r6_
        run_job(16'h2000, 16'd5, 8'h3C, 1'b1);
        do begin @(posedge clk); #1; end while (len_left != 16'd3);
        @(negedge clk); bus_avail = 1'b0;
        held = 0;
        for (int i = 0; i < 21; i++) begin
            @(negedge clk); #1;
            if (dma_n == 1'b0 && bus_drive == 1'b0 && len_left == 16'd3) held++;
        end
        check(held == 21, "R6 request held, bus released", 32'(held), 32'd21);
        // raise during phase two high so the resume must wait
        do begin @(negedge clk); #1; end while (!phi2);
        bus_avail = 1'b1;
        @(negedge clk); #1;
        check(bus_drive == 1'b0, "R6 no resume in high phase", {31'd0, bus_drive}, 0);
        // writes while busy must be ignored, r9_
        wr(2'd0, 16'h7777);
        wr(2'd3, 16'd0);
        wait_done();
        end_checks(16'h2000, 16'd5, "job2");

        // R9: base register kept 0x2000; only length and trigger rewritten
        wr(2'd1, 16'd2);
        push_job(16'h2000, 16'd2, 8'h3C, 1'b0);
        wr(2'd3, 16'd0);
        wait_done();
        end_checks(16'h2000, 16'd2, "job3 R9");

        // R8: zero count
        wr(2'd1, 16'd0);
        wr(2'd3, 16'd0);
        held = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk); #1;
            if (dma_n == 1'b1 && bus_drive == 1'b0) held++;
        end
        check(held == 32, "R8 zero count idle", 32'(held), 32'd32);

        // R3: armed while bus-available low
        bus_avail = 1'b0;
        run_job(16'h0400, 16'd1, 8'h11, 1'b0);
        held = 0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk); #1;
            if (dma_n == 1'b1) held++;
        end
        check(held == 24, "R3 no request while unavailable", 32'(held), 32'd24);
        bus_avail = 1'b1;
        wait_done();
        end_checks(16'h0400, 16'd1, "job4 R3");

        // R5: address wrap
        run_job(16'hFFFF, 16'd2, 8'h5A, 1'b1);
        wait_done();
        end_checks(16'hFFFF, 16'd2, "job5 wrap");

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule